// File: doc/BRIEF.md
# Pixel-to-Frame Segmentation Packer

This block sits in the link clock domain behind the clock-crossing buffer that holds captured pixels. It takes one pixel word at a time and packs its bits into a continuous stream of 16-bit frame payloads. One frame leaves the block on every link clock cycle. Each pixel has 10, 12, 18 or 24 data bits. A configuration code can add the three control bits (horizontal sync, vertical sync, data enable) after the data bits. Pixels pack back to back, so a pixel can be split across two frames.

The packer realigns whenever data enable goes from low to high. It closes the partly filled frame with zero bits, and the pixel that starts the new set begins at bit 0 of a fresh frame. This gives the far end a fixed point to lock onto, even when the control bits are not sent at all. On a cycle where fewer than 16 payload bits are held, the packer sends a frame marked as dummy instead, and the receiver throws that frame away.

Top module: `pixseg_packer`

## Requirements
- R1: The width code `cfg_width` sets how many data bits each pixel carries: 00 gives 10, 01 gives 12, 10 gives 18 and 11 gives 24, always the low bits of `px_data`.
- R2: With control code `cfg_ctrl` = 11, every pixel carries three more bits after its data bits, in this order: hsync at offset W, vsync at W+1 and data enable at W+2, where W is the data width.
- R3: With control code 10, only pixels with an even index carry the control bits. The index counts accepted pixels and restarts at 0 with the pixel that raises data enable. The bit-count of a pixel is W+3 with control bits and W without them.
- R4: With control codes 00 and 01, no pixel carries control bits, so each pixel is exactly W bits.
- R5: Bits are packed from the least significant end: bit 0 of a frame is the oldest payload bit. A pixel that does not fit in the rest of a frame continues at bit 0 of the next non-dummy frame.
- R6: A pixel accepted with data enable high after an accepted pixel with it low, or the first such pixel after reset, starts a new set. If a partial frame is held at that point, it is sent padded with zeros in the upper bits, and the new pixel starts at bit 0 of the next frame.
- R7: Outside reset, `fr_valid` is high on every cycle. If fewer than 16 payload bits are held, the frame is sent with `fr_dummy` high and `fr_data` all zero.
- R8: `px_ready` is high only while fewer than 16 payload bits are held. A pixel is taken when `px_valid` and `px_ready` are both high.
- R9: While reset is active, `fr_valid` is low, `px_ready` is high and no bits are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 2 | Pixel data width code |
| cfg_ctrl | input | 2 | Control bit transmit mode code |
| px_valid | input | 1 | A pixel word is offered |
| px_data | input | 24 | Pixel data, low bits used |
| px_hsync | input | 1 | Horizontal sync of the pixel |
| px_vsync | input | 1 | Vertical sync of the pixel |
| px_de | input | 1 | Data enable of the pixel |
| px_ready | output | 1 | Pixel is taken this cycle if offered |
| fr_valid | output | 1 | A frame slot is driven |
| fr_dummy | output | 1 | Frame carries no payload |
| fr_data | output | 16 | Frame payload |

## Verification
The hardest case to reach is a data enable rising edge that arrives while part of a frame is still held. This has to happen for many different held bit counts, and sometimes with a realigning pixel long enough to fill more than one frame. The bench reaches it by leaving idle gaps between pixel sets, so a residual stays behind. It then starts each new set with a rising edge and sweeps every width code and control code, so the residual count differs from one set to the next. A reference bit queue, padded at each rise, predicts every non-dummy frame, and the bench checks that every dummy frame is all zero.

// File: rtl/pixseg_pkg.sv
package pixseg_pkg;

    localparam int FRAME_W = 16;
    localparam int DATA_W  = 24;
    localparam int CTRL_N  = 3;
    localparam int PIX_W   = DATA_W + CTRL_N;
    localparam int LEN_W   = $clog2(PIX_W + 1);

    typedef enum logic [1:0] {
        WID_10 = 2'b00,
        WID_12 = 2'b01,
        WID_18 = 2'b10,
        WID_24 = 2'b11
    } wid_e;

    typedef enum logic [1:0] {
        CM_NEVER = 2'b00,
        CM_RSVD  = 2'b01,
        CM_EVEN  = 2'b10,
        CM_ALL   = 2'b11
    } cmode_e;

    typedef struct packed {
        logic [PIX_W-1:0] bits;
        logic [LEN_W-1:0] len;
    } pixw_t;

    function automatic logic [LEN_W-1:0] data_bits(wid_e w);
        case (w)
            WID_10:  return LEN_W'(10);
            WID_12:  return LEN_W'(12);
            WID_18:  return LEN_W'(18);
            default: return LEN_W'(24);
        endcase
    endfunction

    function automatic logic ctrl_on(cmode_e m, logic even);
        case (m)
            CM_ALL:  return 1'b1;
            CM_EVEN: return even;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pixseg_fmt.sv
module pixseg_fmt
    import pixseg_pkg::*;
(
    input  logic [1:0]        cfg_width,
    input  logic [1:0]        cfg_ctrl,
    input  logic [DATA_W-1:0] data,
    input  logic              hs,
    input  logic              vs,
    input  logic              de,
    input  logic              even,
    output pixw_t             word
);
    logic [LEN_W-1:0]  dbits;
    logic [DATA_W-1:0] dmask;
    logic              send_c;

    always_comb begin
        dbits  = data_bits(wid_e'(cfg_width));
        send_c = ctrl_on(cmode_e'(cfg_ctrl), even);
        for (int i = 0; i < DATA_W; i++) begin
            dmask[i] = (i < int'(dbits));
        end
        word.bits = {{CTRL_N{1'b0}}, data & dmask};
        word.len  = dbits;
        if (send_c) begin
            word.bits = word.bits | (PIX_W'({de, vs, hs}) << dbits);
            word.len  = dbits + LEN_W'(CTRL_N);
        end
    end

    always_comb begin
        assert (word.len >= LEN_W'(10) && word.len <= LEN_W'(PIX_W)); // R3
    end

endmodule

// File: rtl/pixseg_phase.sv
module pixseg_phase (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic pix_de,
    output logic rise,
    output logic even
);
    logic prev_q;
    logic even_q;

    assign rise = pix_de & ~prev_q;
    assign even = rise | even_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            even_q <= 1'b1;
        end else if (take) begin
            prev_q <= pix_de;
            even_q <= ~even;
        end
    end

    AST_RISE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (take && rise) |=> (prev_q && !even_q)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(prev_q) && $stable(even_q))); // R6

endmodule

// File: rtl/pixseg_accum.sv
module pixseg_accum
    import pixseg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic               realign,
    input  pixw_t              word,
    output logic               room,
    output logic               fr_valid,
    output logic               fr_dummy,
    output logic [FRAME_W-1:0] fr_data
);
    localparam int BUF_W = FRAME_W - 1 + PIX_W;
    localparam int CNT_W = $clog2(BUF_W + 1);
    localparam logic [CNT_W-1:0] FR_CNT  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(PIX_W);

    logic [BUF_W-1:0]   buf_q, buf_d, merged, ext;
    logic [CNT_W-1:0]   cnt_q, cnt_d, mcnt;
    logic [FRAME_W-1:0] frame_d;
    logic               dummy_d;

    assign room = (cnt_q < FR_CNT);

    always_comb begin
        ext     = {{(BUF_W-PIX_W){1'b0}}, word.bits};
        merged  = buf_q | (take ? (ext << cnt_q) : '0);
        mcnt    = cnt_q + (take ? CNT_W'(word.len) : '0);
        frame_d = '0;
        dummy_d = 1'b1;
        if (take && realign && cnt_q != '0) begin
            frame_d = buf_q[FRAME_W-1:0];
            dummy_d = 1'b0;
            buf_d   = ext;
            cnt_d   = CNT_W'(word.len);
        end else if (mcnt >= FR_CNT) begin
            frame_d = merged[FRAME_W-1:0];
            dummy_d = 1'b0;
            buf_d   = merged >> FRAME_W;
            cnt_d   = mcnt - FR_CNT;
        end else begin
            buf_d   = merged;
            cnt_d   = mcnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q    <= '0;
            cnt_q    <= '0;
            fr_valid <= 1'b0;
            fr_dummy <= 1'b1;
            fr_data  <= '0;
        end else begin
            buf_q    <= buf_d;
            cnt_q    <= cnt_d;
            fr_valid <= 1'b1;
            fr_dummy <= dummy_d;
            fr_data  <= frame_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= MAX_CNT); // R8

    AST_NO_TAKE_FULL: assert property (@(posedge clk) disable iff (rst)
        take |-> (cnt_q < FR_CNT)); // R8

    AST_REALIGN_EMIT: assert property (@(posedge clk) disable iff (rst)
        (take && realign && cnt_q != '0) |=> (fr_valid && !fr_dummy)); // R6

    AST_FULL_EMITS: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= FR_CNT) |=> !fr_dummy); // R5

endmodule

// File: rtl/pixseg_packer.sv
module pixseg_packer
    import pixseg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_width,
    input  logic [1:0]         cfg_ctrl,
    input  logic               px_valid,
    input  logic [DATA_W-1:0]  px_data,
    input  logic               px_hsync,
    input  logic               px_vsync,
    input  logic               px_de,
    output logic               px_ready,
    output logic               fr_valid,
    output logic               fr_dummy,
    output logic [FRAME_W-1:0] fr_data
);
    logic  take;
    logic  rise;
    logic  even;
    logic  room;
    pixw_t word;

    assign px_ready = room;
    assign take     = px_valid & room;

    pixseg_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .pix_de (px_de),
        .rise   (rise),
        .even   (even)
    );

    pixseg_fmt u_fmt (
        .cfg_width (cfg_width),
        .cfg_ctrl  (cfg_ctrl),
        .data      (px_data),
        .hs        (px_hsync),
        .vs        (px_vsync),
        .de        (px_de),
        .even      (even),
        .word      (word)
    );

    pixseg_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .realign  (rise),
        .word     (word),
        .room     (room),
        .fr_valid (fr_valid),
        .fr_dummy (fr_dummy),
        .fr_data  (fr_data)
    );

    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (fr_valid && fr_dummy) |-> (fr_data == '0)); // R7

    AST_VALID_RUN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> fr_valid); // R7

endmodule

// File: tb/sim_pixseg_packer.sv
module sim_pixseg_packer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_width = 2'b00;
    logic [1:0]  cfg_ctrl = 2'b00;
    logic        px_valid = 1'b0;
    logic [23:0] px_data = '0;
    logic        px_hsync = 1'b0;
    logic        px_vsync = 1'b0;
    logic        px_de = 1'b0;
    logic        px_ready;
    logic        fr_valid;
    logic        fr_dummy;
    logic [15:0] fr_data;

    int    errors = 0;
    int    checks = 0;
    bit    expq[$];
    int    tot = 0;
    bit    prev_m = 1'b0;
    bit    even_m = 1'b1;
    bit    mon_on = 1'b0;
    string cur_tag = "R1";
    logic [23:0] lfsr = 24'h5a3c91;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    pixseg_packer u0 (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_ctrl(cfg_ctrl),
        .px_valid(px_valid), .px_data(px_data), .px_hsync(px_hsync),
        .px_vsync(px_vsync), .px_de(px_de), .px_ready(px_ready),
        .fr_valid(fr_valid), .fr_dummy(fr_dummy), .fr_data(fr_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] c);
        case (c)
            2'b00:   return 10;
            2'b01:   return 12;
            2'b10:   return 18;
            default: return 24;
        endcase
    endfunction

    // Driver: offers a pixel, and once it will be taken pushes its bits into the scoreboard
    task automatic send(input logic hs, input logic vs, input logic de);
        bit rise;
        bit ev;
        bit on;
        int n;
        lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
        @(negedge clk);
        px_valid = 1'b1;
        px_data  = lfsr;
        px_hsync = hs;
        px_vsync = vs;
        px_de    = de;
        while (!px_ready) @(negedge clk);
        rise = de && !prev_m;
        ev   = rise ? 1'b1 : even_m;
        n    = wbits(cfg_width);
        on   = (cfg_ctrl == 2'b11) || (cfg_ctrl == 2'b10 && ev);
        if (rise && (tot % 16) != 0) begin
            // R6: zero padding closes the partial frame
            for (int k = tot % 16; k < 16; k++) begin
                expq.push_back(1'b0);
                tot++;
            end
        end
        for (int k = 0; k < n; k++) begin
            expq.push_back(lfsr[k]);
            tot++;
        end
        if (on) begin
            expq.push_back(hs);
            expq.push_back(vs);
            expq.push_back(de);
            tot += 3;
        end
        prev_m = de;
        even_m = !ev;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        px_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected bits for every payload frame
    always @(negedge clk) begin
        if (mon_on && !rst && fr_valid) begin
            if (!fr_dummy) begin
                if (expq.size() < 16) begin
                    check(1'b0, {cur_tag, " R5 unexpected frame"}, {16'h0, fr_data}, 32'(expq.size()));
                end else begin
                    logic [15:0] e;
                    for (int k = 0; k < 16; k++) e[k] = expq.pop_front();
                    check(fr_data == e, {cur_tag, " R5 R6 frame"}, {16'h0, fr_data}, {16'h0, e});
                end
            end else begin
                check(fr_data == 16'h0, "R7 dummy data", {16'h0, fr_data}, 32'h0);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(fr_valid == 1'b0, "R9 valid in reset", {31'h0, fr_valid}, 32'h0);
        check(px_ready == 1'b1, "R9 ready in reset", {31'h0, px_ready}, 32'h1);
        rst = 1'b0;
        mon_on = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(fr_valid == 1'b1, "R7 valid after reset", {31'h0, fr_valid}, 32'h1);
        check(fr_dummy == 1'b1, "R7 dummy when empty", {31'h0, fr_dummy}, 32'h1);
        check(px_ready == 1'b1, "R8 ready when empty", {31'h0, px_ready}, 32'h1);

        for (int wc = 0; wc < 4; wc++) begin
            for (int md = 0; md < 4; md++) begin
                cfg_width = 2'(wc);
                cfg_ctrl  = 2'(md);
                case (md)
                    0:       cur_tag = "R1 R4";
                    1:       cur_tag = "R1 R4";
                    2:       cur_tag = "R1 R3";
                    default: cur_tag = "R1 R2";
                endcase
                send(1'b1, 1'b1, 1'b1);
                for (int p = 0; p < 6; p++) send(p[0], p[1], 1'b1);
                send(1'b0, 1'b1, 1'b0);
                send(1'b1, 1'b0, 1'b0);
                if (md == 2) begin
                    // R3: a second rise after an odd number of pixels restarts the even count
                    send(1'b0, 1'b0, 1'b1);
                    send(1'b1, 1'b1, 1'b1);
                    send(1'b0, 1'b1, 1'b0);
                end
                idle(6 + wc);
            end
            // back to back long pixels force stalls while frames drain
            cfg_ctrl = 2'b11;
            cur_tag  = "R8";
            for (int p = 0; p < 10; p++) send(1'b0, 1'b0, 1'b1);
            idle(5);
        end

        // R6: final rise flushes the residual
        cfg_width = 2'b11;
        cfg_ctrl  = 2'b00;
        cur_tag   = "R6";
        send(1'b0, 1'b0, 1'b0);
        send(1'b1, 1'b1, 1'b1);
        idle(8);
        check(expq.size() < 16, "R5 leftover bits", 32'(expq.size()), 32'd15);
        check(fr_dummy == 1'b1, "R7 dummy when idle", {31'h0, fr_dummy}, 32'h1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule